// File: doc/BRIEF.md
# Lockable Outer-Bank Configuration Registers

This block keeps the extra configuration bytes of a multi-game cartridge board that sits beside an inner bank controller. CPU writes into the $5000–$5FFF window land in one of four byte slots, chosen by the two lowest address bits. A write whose bit 7 is set is stored and also closes the window for good. After that the four slots stay frozen until the next reset.

A fifth byte, the mode shadow, is only filled while the forced-bank mode is on, which is slot 0 bit 2. In that mode every CPU write to $8000–$FFFF copies its data into the shadow, and the same write still goes on to the inner controller. The nametable mirroring output then comes from bit 2 of the shadow. Outside that mode the output follows the inner controller's own choice. Reads from the window always give zero.

Top module: `outer_cfg_regs`

## Requirements
- R1: A write strobe with address bits [15:12] equal to 4'h5 stores the data byte into slot address[1:0]. No other address bits take part. Slot k sits at bits [8k+7:8k] of `slots_q`.
- R2: A window write with data bit 7 set is itself stored. On that same clock edge `lock_q` goes to 1.
- R3: While `lock_q` is 1, window writes leave all four slots unchanged, and `lock_q` stays 1 until reset.
- R4: Reset clears the four slots, the mode shadow and the lock to zero, which selects normal mode. After reset, window writes are accepted again.
- R5: While slot 0 bit 2 is 1, a write strobe with address bit 15 set copies the full data byte into `mode_q` on that edge.
- R6: While slot 0 bit 2 is 0, writes to $8000–$FFFF leave `mode_q` unchanged.
- R7: `mode_q` ignores the lock. Window writes never change it, including writes to slot 3.
- R8: While slot 0 bit 2 is 1, `mirror_vert` equals `mode_q` bit 2 (1 = vertical, 0 = horizontal), whatever the value of `inner_mirror_vert`.
- R9: While slot 0 bit 2 is 0, `mirror_vert` follows `inner_mirror_vert` in the same cycle.
- R10: Writes to addresses outside both windows (for example $4000 and $6000) change no register.
- R11: `cfg_rd_data` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| inner_mirror_vert | input | 1 | Mirroring choice of the inner controller (1 = vertical) |
| slots_q | output | 32 | Four configuration slots, slot k at bits [8k+7:8k] |
| mode_q | output | 8 | Mode shadow byte |
| lock_q | output | 1 | Window lock flag |
| mirror_vert | output | 1 | Final mirroring select (1 = vertical) |
| cfg_rd_data | output | 8 | Read data for the window, always zero |

## Verification
Two functions can fall on the same edge.

The first is a locking write. It must both store its byte and raise the lock. The bench sends a slot-2 write of 0x85 and expects the slot and the lock flag to change together, then checks that the very next window write is refused.

The second is a slot-0 write that sets or clears bit 2. On the edge where that write is stored, the source of `mirror_vert` switches from the inner input to the shadow bit. The bench holds the inner input opposite to the shadow bit across that write, so a wrong source shows up at once in the next compare.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int NUM_SLOTS = 4;
  localparam int IDX_W     = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic             win_we;
    logic             hi_we;
    logic [IDX_W-1:0] idx;
  } wr_dec_t;
endpackage

// File: rtl/ocr_decode.sv
module ocr_decode
  import ocr_pkg::*;
#(
  parameter logic [3:0] WIN_NIB = 4'h5
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  output wr_dec_t           dec,
  output logic              win_sel
);
  always_comb begin
    win_sel    = (cpu_addr[ADDR_W-1 -: 4] == WIN_NIB);
    dec.win_we = cpu_we & win_sel;
    dec.hi_we  = cpu_we & cpu_addr[ADDR_W-1];
    dec.idx    = cpu_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/ocr_slot_file.sv
module ocr_slot_file
  import ocr_pkg::*;
#(
  parameter int LOCK_BIT = DATA_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wr_dec_t                     dec,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_SLOTS*DATA_W-1:0] slots_q,
  output logic                        lock_q
);
  logic accept;
  logic lock_nxt;

  always_comb begin
    accept   = dec.win_we & ~lock_q;
    lock_nxt = lock_q | (accept & wdata[LOCK_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_nxt;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = accept & (dec.idx == IDX_W'(i));
      d  = en ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign slots_q[i*DATA_W +: DATA_W] = q;
  end

  // R3: the lock never drops on its own
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R3: locked slots do not move
  a_r3_slots_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(slots_q));
  // R2: a locking write raises the flag on its own edge
  a_r2_lock_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.win_we && wdata[LOCK_BIT]) |=> lock_q);
endmodule

// File: rtl/ocr_mode_shadow.sv
module ocr_mode_shadow
  import ocr_pkg::*;
#(
  parameter int MIRROR_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              mode_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inner_mirror_vert,
  output logic [DATA_W-1:0] mode_q,
  output logic              mirror_vert
);
  logic              cap;
  logic [DATA_W-1:0] mode_nxt;

  always_comb begin
    cap         = hi_we & mode_en;
    mode_nxt    = cap ? wdata : mode_q;
    mirror_vert = mode_en ? mode_q[MIRROR_BIT] : inner_mirror_vert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_nxt;
  end

  // R5: captured byte equals the written byte
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && mode_en) |=> (mode_q == $past(wdata)));
  // R6 / R7: shadow holds without a qualified write
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_we && mode_en) |=> $stable(mode_q));
endmodule

// File: rtl/outer_cfg_regs.sv
module outer_cfg_regs
  import ocr_pkg::*;
#(
  parameter logic [3:0] WIN_NIB    = 4'h5,
  parameter int         MODE_BIT   = 2,
  parameter int         MIRROR_BIT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  input  logic                        cpu_we,
  input  logic                        inner_mirror_vert,
  output logic [NUM_SLOTS*DATA_W-1:0] slots_q,
  output logic [DATA_W-1:0]           mode_q,
  output logic                        lock_q,
  output logic                        mirror_vert,
  output logic [DATA_W-1:0]           cfg_rd_data
);
  logic [1:0] rst_sync;
  logic       rst_n_i;
  wr_dec_t    dec;
  logic       win_sel;
  logic       mode_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  ocr_decode #(.WIN_NIB(WIN_NIB)) u_dec (
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .dec      (dec),
    .win_sel  (win_sel)
  );

  ocr_slot_file u_slots (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .dec     (dec),
    .wdata   (cpu_wdata),
    .slots_q (slots_q),
    .lock_q  (lock_q)
  );

  assign mode_en = slots_q[MODE_BIT];

  ocr_mode_shadow #(.MIRROR_BIT(MIRROR_BIT)) u_shadow (
    .clk               (clk),
    .rst_n             (rst_n_i),
    .hi_we             (dec.hi_we),
    .mode_en           (mode_en),
    .wdata             (cpu_wdata),
    .inner_mirror_vert (inner_mirror_vert),
    .mode_q            (mode_q),
    .mirror_vert       (mirror_vert)
  );

  // R11: the window reads back as zero
  assign cfg_rd_data = win_sel ? '0 : '0;

  // R10: a write outside both windows leaves all state alone
  a_r10_outside: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_we && !win_sel && !cpu_addr[ADDR_W-1]) |=>
      ($stable(slots_q) && $stable(mode_q) && $stable(lock_q)));
endmodule

// File: tb/outer_cfg_regs_bench.sv
module outer_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        inner_mirror_vert = 1'b0;
  logic [31:0] slots_q;
  logic [7:0]  mode_q;
  logic        lock_q;
  logic        mirror_vert;
  logic [7:0]  cfg_rd_data;

  always #4 clk = ~clk;

  outer_cfg_regs u_outer_cfg_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .inner_mirror_vert(inner_mirror_vert), .slots_q(slots_q),
    .mode_q(mode_q), .lock_q(lock_q), .mirror_vert(mirror_vert),
    .cfg_rd_data(cfg_rd_data)
  );

  typedef struct packed {
    logic [31:0] slots;
    logic [7:0]  mode;
    logic        lock;
    logic        mirror;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  logic [7:0] m_slot [4];
  logic [7:0] m_mode;
  logic       m_lock;

  function automatic snap_t model_snap();
    snap_t s;
    s.slots  = {m_slot[3], m_slot[2], m_slot[1], m_slot[0]};
    s.mode   = m_mode;
    s.lock   = m_lock;
    s.mirror = m_slot[0][2] ? m_mode[2] : inner_mirror_vert;
    return s;
  endfunction

  task automatic push(string tag);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    if (a[15:12] == 4'h5 && !m_lock) begin
      m_slot[a[1:0]] = d;
      if (d[7]) m_lock = 1'b1;
    end
    if (a[15] && m_slot[0][2]) m_mode = d;
    @(posedge clk); #1;
    cpu_we = 1'b0;
    push(tag);
  endtask

  task automatic set_inner(input logic v, input string tag);
    @(negedge clk); #1;
    inner_mirror_vert = v;
    push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_mode = '0; m_lock = 1'b0;
    push(tag);
    @(negedge clk); @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      snap_t e;
      string t;
      bit    bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      bad = 0;
      if (slots_q !== e.slots) begin
        $display("FAIL %s slots act=%h exp=%h", t, slots_q, e.slots); bad = 1;
      end
      if (mode_q !== e.mode) begin
        $display("FAIL %s mode act=%h exp=%h", t, mode_q, e.mode); bad = 1;
      end
      if (lock_q !== e.lock) begin
        $display("FAIL %s lock act=%b exp=%b", t, lock_q, e.lock); bad = 1;
      end
      if (mirror_vert !== e.mirror) begin
        $display("FAIL %s mirror act=%b exp=%b", t, mirror_vert, e.mirror); bad = 1;
      end
      if (cfg_rd_data !== 8'h00) begin
        $display("FAIL R11 (%s) rd_data act=%h exp=00", t, cfg_rd_data); bad = 1;
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      $display("FAIL watchdog act=running exp=finished");
      n_bad++;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_mode = '0; m_lock = 1'b0;
    repeat (2) @(negedge clk);
    do_reset("R4 reset state");
    set_inner(1'b1, "R9 inner vertical passes");
    set_inner(1'b0, "R9 inner horizontal passes");
    wr(16'h5001, 8'h10, "R1 slot1");
    wr(16'h5FF6, 8'h2A, "R1 high addr bits ignored, slot2");
    wr(16'h5003, 8'h33, "R7 slot3 write leaves mode");
    wr(16'h6000, 8'h55, "R10 6000 ignored");
    wr(16'h4000, 8'h77, "R10 4000 ignored");
    wr(16'h8000, 8'h04, "R6 no copy in normal mode");
    set_inner(1'b1, "R9 inner vertical before mode");
    wr(16'h5000, 8'h04, "R8 mode on, mirror from shadow");
    wr(16'hA001, 8'h04, "R5 copy, R8 vertical");
    set_inner(1'b0, "R8 inner ignored in mode");
    wr(16'hFFFF, 8'hF3, "R5 copy full byte, R8 horizontal");
    wr(16'h5002, 8'h85, "R2 locking write stored");
    wr(16'h5002, 8'h11, "R3 slot2 refused");
    wr(16'h5000, 8'h00, "R3 slot0 refused");
    wr(16'hC000, 8'h24, "R7 shadow updates under lock");
    do_reset("R4 reset clears lock");
    wr(16'h5001, 8'h22, "R4 window writable after reset");
    wr(16'h5000, 8'h80, "R2 lock with mode off");
    wr(16'h8000, 8'h99, "R6 no copy while locked normal");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule